// File: doc/BRIEF.md
# Cascadable Edge/Level Interrupt Controller

This block gathers interrupt sources in banks of 32 and reduces them to a single request line. Within a bank, each source is either edge-sensitive or level-sensitive, and a fixed per-bank mask chosen at build time decides which. Edge sources are registered. A rising edge on an enabled edge source sets a sticky event bit, and software clears that bit by writing a one to the acknowledge register. Level sources never latch. Their live, registered state appears in the level register, and while enabled they assert the request directly.

Software uses a small word-addressed register bus that has one-cycle read latency. One instance can serve 32 sources or 64. The request output of a secondary instance can drive a source input of a primary instance, which forms a cascade. Turning on an enable whose source line is already high creates no event, so software has to inspect the level register to catch that case.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every event, enable and level register reads 0, bus_rdata is 0 and irq_out is low.
- R2: Each bank holds four word registers: event at +0x0, enable at +0x4, ack at +0x8 and level at +0xC. Bank 0 sits at byte offset 0x20 and bank 1 at 0x10. Reading ack returns 0. Any other address reads 0 and ignores writes, and so does a bank that is not built, a misaligned address, or anything below 0x10 or at 0x30 and above.
- R3: A read returns its data on bus_rdata one clock after bus_rd is sampled. A write to enable is returned by the next read of that enable register.
- R4: On an edge source, a 0-to-1 transition of the registered input sets that source's event bit when its enable bit is set at that edge.
- R5: Writing ack clears every event bit written as 1. Bits written as 0 leave their event bits unchanged.
- R6: Setting an enable bit while that source's input is already high sets no event bit and does not raise irq_out.
- R7: A rising edge on a source whose enable bit is clear is lost. The event bit stays 0 even after the source is enabled later.
- R8: Sources whose level-mask bit is set never set an event bit. The level register reports the registered input of every source in the bank, whatever its type. The default masks are 0x1ff00000 for bank 0 and 0 for bank 1.
- R9: irq_out is high exactly when some bank has a bit set in (event OR (level input AND level mask)) AND enable. With every enable register at 0, irq_out is low.
- R10: When an ack write and a new enabled rising edge hit the same source in the same cycle, the event bit stays set.
- R11: The irq_out of a secondary instance, fed into a level source of a primary instance, raises the primary's irq_out once that source is enabled in the primary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address within the 0x40 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| src_in | input | NUM_BANKS*32 | Interrupt sources, bank 0 in bits 31:0 |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that bus_wr and bus_rd are never high in the same cycle and that each source input is synchronous to clk. The stimulus never issues a read and a write together. It changes sources only on the falling edge, and it waits at least one full cycle after a source change before it reads or samples irq_out. The cascade scenario raises the secondary's source only after the secondary is configured, so the primary's level input changes only in a cycle the bench controls.

// File: rtl/cic_pkg.sv
// Package: shared constants and address helpers for the cascadable
// interrupt controller. Assumes a 0x40-byte window of 32-bit words.
package cic_pkg;
    localparam int DW     = 32;  // register and bank width
    localparam int AW     = 6;   // byte address width of the window
    localparam int MAXBNK = 2;   // largest supported bank count

    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_sel_e;

    // Address bits [5:4] that select a given bank.
    function automatic logic [1:0] bank_slot(input int b);
        return (b == 0) ? 2'b10 : 2'b01;
    endfunction
endpackage

// File: rtl/cic_bank.sv
// Module: one bank of 32 sources. It registers the inputs, latches
// enabled rising edges on edge sources, and clears them on ack.
// Assumes src_i is synchronous to clk and that en_wr and ack_wr
// come from a decoder that never asserts both at once.
module cic_bank #(
    parameter logic [31:0] LVL_MASK = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] src_i,
    input  logic        en_wr,
    input  logic        ack_wr,
    input  logic [31:0] wdata,
    output logic [31:0] event_o,
    output logic [31:0] enable_o,
    output logic [31:0] level_o,
    output logic        req_o
);
    logic [31:0] in_q, event_q, enable_q;
    logic [31:0] rise_v, new_ev, ack_mask;

    // Rising edges, qualified by enable and edge-type mask.
    always_comb begin
        rise_v   = src_i & ~in_q;
        new_ev   = rise_v & enable_q & ~LVL_MASK;
        ack_mask = ack_wr ? wdata : 32'h0;
    end

    // Input register: one sample of each source per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= src_i;
    end

    // Enable register: loaded in full by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable_q <= '0;
        else if (en_wr) enable_q <= wdata;
    end

    // Event register: ack clears first, then a new edge sets again.
    always_ff @(posedge clk) begin
        if (!rst_n) event_q <= '0;
        else        event_q <= (event_q & ~ack_mask) | new_ev;
    end

    assign event_o  = event_q;
    assign enable_o = enable_q;
    assign level_o  = in_q;
    assign req_o    = |((event_q | (in_q & LVL_MASK)) & enable_q);

    // R3
    en_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> enable_q == $past(wdata));
    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> (event_q & $past(wdata & ~new_ev)) == 32'h0);
    // R10
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> (event_q & $past(new_ev)) == $past(new_ev));
    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (event_q & ~$past(event_q) & ~$past(rise_v & enable_q)) == 32'h0);
endmodule

// File: rtl/cic_decode.sv
// Module: address decode and read mux. It makes per-bank write
// strobes and registers read data one cycle after bus_rd.
// Assumes word-aligned accesses. Anything else is ignored and reads as 0.
module cic_decode
    import cic_pkg::*;
#(
    parameter int NUM_BANKS = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [AW-1:0]            bus_addr,
    input  logic [NUM_BANKS-1:0][DW-1:0] ev_i,
    input  logic [NUM_BANKS-1:0][DW-1:0] en_i,
    input  logic [NUM_BANKS-1:0][DW-1:0] lv_i,
    output logic [NUM_BANKS-1:0]     en_wr_o,
    output logic [NUM_BANKS-1:0]     ack_wr_o,
    output logic [DW-1:0]            rdata_o
);
    logic [NUM_BANKS-1:0] hit;
    reg_sel_e             rsel;
    logic [DW-1:0]        rd_mux;

    assign rsel = reg_sel_e'(bus_addr[3:2]);

    // Bank hit decode, one comparator per built bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        assign hit[b]      = (bus_addr[5:4] == bank_slot(b)) && (bus_addr[1:0] == 2'b00);
        assign en_wr_o[b]  = bus_wr && hit[b] && (rsel == REG_ENABLE);
        assign ack_wr_o[b] = bus_wr && hit[b] && (rsel == REG_ACK);
    end

    // Read mux over the built banks. Ack and misses read as 0.
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit[b]) begin
                case (rsel)
                    REG_EVENT:  rd_mux = ev_i[b];
                    REG_ENABLE: rd_mux = en_i[b];
                    REG_LEVEL:  rd_mux = lv_i[b];
                    default:    rd_mux = '0;
                endcase
            end
        end
    end

    // Read data register: loaded on each read, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_o <= '0;
        else if (bus_rd) rdata_o <= rd_mux;
    end

    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_wr_o, ack_wr_o}));
endmodule

// File: rtl/cascade_irq_ctrl.sv
// Module: top of the interrupt controller. It builds NUM_BANKS banks
// with fixed level masks and ORs their requests into irq_out.
// Assumes NUM_BANKS is 1 or 2 and that read and write are never both high.
module cascade_irq_ctrl
    import cic_pkg::*;
#(
    parameter int          NUM_BANKS     = 2,
    parameter logic [31:0] LEVEL_MASK_B0 = 32'h1ff0_0000,
    parameter logic [31:0] LEVEL_MASK_B1 = 32'h0000_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [5:0]              bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_BANKS*32-1:0] src_in,
    output logic                    irq_out
);
    localparam int NB = (NUM_BANKS > MAXBNK) ? MAXBNK : NUM_BANKS;

    logic [NB-1:0][DW-1:0] ev_w, en_w, lv_w;
    logic [NB-1:0]         en_wr_w, ack_wr_w, req_w;

    cic_decode #(.NUM_BANKS(NB)) dec_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .ev_i(ev_w), .en_i(en_w), .lv_i(lv_w),
        .en_wr_o(en_wr_w), .ack_wr_o(ack_wr_w), .rdata_o(bus_rdata)
    );

    // One bank per 32 sources. The mask is picked by bank index.
    for (genvar b = 0; b < NB; b++) begin : g_bank
        cic_bank #(.LVL_MASK((b == 0) ? LEVEL_MASK_B0 : LEVEL_MASK_B1)) bank_i (
            .clk(clk), .rst_n(rst_n), .src_i(src_in[b*32 +: 32]),
            .en_wr(en_wr_w[b]), .ack_wr(ack_wr_w[b]), .wdata(bus_wdata),
            .event_o(ev_w[b]), .enable_o(en_w[b]), .level_o(lv_w[b]),
            .req_o(req_w[b])
        );
    end

    assign irq_out = |req_w;

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w == '0) |-> !irq_out);
    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (bus_rdata == 32'h0) && !irq_out);
endmodule

// File: tb/cascade_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        p_wr = 0, p_rd = 0, s_wr = 0, s_rd = 0;
    logic [5:0]  p_addr = 0, s_addr = 0;
    logic [31:0] p_wdata = 0, s_wdata = 0, p_rdata, s_rdata;
    logic [63:0] src_p = '0;
    logic [31:0] src_s = '0;
    logic        p_irq, s_irq;
    logic [63:0] prim_src;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    assign prim_src = src_p | (64'(s_irq) << 20);

    cascade_irq_ctrl #(.NUM_BANKS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(p_wr), .bus_rd(p_rd), .bus_addr(p_addr),
        .bus_wdata(p_wdata), .bus_rdata(p_rdata), .src_in(prim_src), .irq_out(p_irq));

    cascade_irq_ctrl #(.NUM_BANKS(1), .LEVEL_MASK_B0(32'h3ff0_0000)) sec_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(s_wr), .bus_rd(s_rd), .bus_addr(s_addr),
        .bus_wdata(s_wdata), .bus_rdata(s_rdata), .src_in(src_s), .irq_out(s_irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sec, input logic [5:0] a, input logic [31:0] d);
        if (sec) begin s_wr = 1; s_addr = a; s_wdata = d; end
        else     begin p_wr = 1; p_addr = a; p_wdata = d; end
        @(negedge clk);
        p_wr = 0; s_wr = 0;
    endtask

    task automatic rd(input bit sec, input logic [5:0] a, output logic [31:0] d);
        if (sec) begin s_rd = 1; s_addr = a; end
        else     begin p_rd = 1; p_addr = a; end
        @(negedge clk);
        p_rd = 0; s_rd = 0;
        d = sec ? s_rdata : p_rdata;
    endtask

    task automatic rd_chk(input string tag, input bit sec, input logic [5:0] a,
                          input logic [31:0] exp);
        logic [31:0] v;
        rd(sec, a, v);
        check(tag, v, exp);
    endtask

    task automatic clean();
        src_p = '0; src_s = '0;
        @(negedge clk);
        wr(0, 6'h24, 0); wr(0, 6'h14, 0); wr(1, 6'h24, 0);
        wr(0, 6'h28, 32'hffff_ffff); wr(0, 6'h18, 32'hffff_ffff);
        wr(1, 6'h28, 32'hffff_ffff);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 rdata", p_rdata, 0);
        check("R1 irq", {31'b0, p_irq}, 0);
        rd_chk("R1 ev0", 0, 6'h20, 0);
        rd_chk("R1 en0", 0, 6'h24, 0);
        rd_chk("R1 lv0", 0, 6'h2c, 0);
        rd_chk("R1 ev1", 0, 6'h10, 0);
        rd_chk("R1 en1", 0, 6'h14, 0);
    endtask

    task automatic t_map();
        wr(0, 6'h24, 32'ha5a5_0000);
        rd_chk("R3 en0 readback", 0, 6'h24, 32'ha5a5_0000);
        wr(0, 6'h14, 32'h1234_5678);
        rd_chk("R3 en1 readback", 0, 6'h14, 32'h1234_5678);
        rd_chk("R2 en0 untouched", 0, 6'h24, 32'ha5a5_0000);
        rd_chk("R2 ack reads 0", 0, 6'h28, 0);
        wr(0, 6'h04, 32'hdead_beef);
        rd_chk("R2 unmapped", 0, 6'h04, 0);
        wr(0, 6'h25, 32'hffff_ffff);
        rd_chk("R2 misaligned ignored", 0, 6'h24, 32'ha5a5_0000);
        wr(1, 6'h14, 32'hffff_ffff);
        rd_chk("R2 absent bank", 1, 6'h14, 0);
        clean();
    endtask

    task automatic t_edge_ack();
        wr(0, 6'h24, 32'h0000_0008);
        src_p[3] = 1; @(negedge clk);
        check("R4 irq", {31'b0, p_irq}, 1);
        rd_chk("R4 event", 0, 6'h20, 32'h8);
        src_p[3] = 0; @(negedge clk);
        rd_chk("R4 sticky", 0, 6'h20, 32'h8);
        wr(0, 6'h28, 32'h0000_0000);
        rd_chk("R5 zero ack", 0, 6'h20, 32'h8);
        wr(0, 6'h28, 32'h0000_0008);
        rd_chk("R5 ack clears", 0, 6'h20, 0);
        check("R5 irq low", {31'b0, p_irq}, 0);
        clean();
    endtask

    task automatic t_disabled();
        src_p[4] = 1; @(negedge clk); @(negedge clk);
        rd_chk("R7 disabled edge", 0, 6'h20, 0);
        wr(0, 6'h24, 32'h10);
        @(negedge clk);
        rd_chk("R6 no event", 0, 6'h20, 0);
        check("R6 no irq", {31'b0, p_irq}, 0);
        rd_chk("R6 level shows", 0, 6'h2c, 32'h10);
        src_p[4] = 0; @(negedge clk);
        src_p[4] = 1; @(negedge clk);
        rd_chk("R4 new edge", 0, 6'h20, 32'h10);
        clean();
    endtask

    task automatic t_level();
        src_p[22] = 1; @(negedge clk);
        rd_chk("R8 level reg", 0, 6'h2c, 32'h0040_0000);
        rd_chk("R8 no event", 0, 6'h20, 0);
        check("R9 level not enabled", {31'b0, p_irq}, 0);
        wr(0, 6'h24, 32'h0040_0000);
        check("R9 level irq", {31'b0, p_irq}, 1);
        rd_chk("R8 still no event", 0, 6'h20, 0);
        src_p[22] = 0; @(negedge clk);
        check("R8 follows input", {31'b0, p_irq}, 0);
        wr(0, 6'h14, 32'h0040_0000);
        src_p[54] = 1; @(negedge clk);
        rd_chk("R8 bank1 edge", 0, 6'h10, 32'h0040_0000);
        src_p[54] = 0; @(negedge clk);
        check("R8 bank1 latched irq", {31'b0, p_irq}, 1);
        wr(0, 6'h14, 0);
        check("R9 enables zero", {31'b0, p_irq}, 0);
        rd_chk("R9 event kept", 0, 6'h10, 32'h0040_0000);
        clean();
    endtask

    task automatic t_race();
        wr(0, 6'h24, 32'h8);
        src_p[3] = 1; @(negedge clk);
        src_p[3] = 0; @(negedge clk);
        src_p[3] = 1; p_wr = 1; p_addr = 6'h28; p_wdata = 32'h8;
        @(negedge clk);
        p_wr = 0;
        rd_chk("R10 edge wins", 0, 6'h20, 32'h8);
        check("R10 irq", {31'b0, p_irq}, 1);
        clean();
    endtask

    task automatic t_cascade();
        wr(1, 6'h24, 32'h1);
        wr(0, 6'h24, 32'h0010_0000);
        check("R11 idle", {31'b0, p_irq}, 0);
        src_s[0] = 1; @(negedge clk);
        check("R11 secondary irq", {31'b0, s_irq}, 1);
        @(negedge clk);
        check("R11 primary irq", {31'b0, p_irq}, 1);
        rd_chk("R11 primary level", 0, 6'h2c, 32'h0010_0000);
        wr(1, 6'h28, 32'h1);
        @(negedge clk);
        check("R11 cascade cleared", {31'b0, p_irq}, 0);
        clean();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_map();
        t_edge_ack();
        t_disabled();
        t_level();
        t_race();
        t_cascade();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule